// File: doc/BRIEF.md
# Processor status flag controller

This block keeps eight system condition flags, each paired with its own enable bit, plus a three-bit interrupt priority level. Software changes the flags with a single command word. That word carries four function bits (enable, disable, clear, set) and an eight-bit mask that selects the flags to act on. Any mix of the four function bits may be set in one write, and all of them act on the selected flags together. The same write also loads the priority level.

Hardware event inputs, one per flag, can set a flag directly. A flag raises an interrupt only while it is both set and enabled. The block ORs those terms into one interrupt request, which it presents together with the programmed level. The priority arbitration that receives that request lies outside the block.

A status word is always available on the read port. It holds the enables, the flags, the summary interrupt bit and the level.

Top module: `sys_flag_ctrl`

## Requirements
- R1: Write-word layout: bit 15 is enable, bit 14 is disable, bit 13 is clear, bit 12 is set. Bits 11:4 form the flag-select mask, where mask bit 4+i selects flag i. Flag bit positions, from 11 down to 4:
  - general-purpose flag
  - host-to-front-end request
  - power failure
  - nonexistent memory
  - uncorrectable memory data
  - corrected memory data
  - interval done
  - front-end-to-host request
- R2: Enable sets the enable bit of each selected flag, and disable clears it. When both are given in one write, disable is applied first, so the selected enables end up set.
- R3: Clear drops each selected flag, and set raises it. When both are given in one write, clear is applied first, so the selected flags end up set.
- R4: Flags and enables that the mask does not select keep their value across a write.
- R5: Every write loads bits 2:0 of the write word as the priority level. The level is returned in read bits 2:0 and driven on `irq_level_o`.
- R6: A high bit on `evt_i` sets the matching flag at the next clock edge, with or without a write. If a write clears that flag in the same cycle, the event wins.
- R7: Read bit 3 and `irq_o` are high exactly when at least one flag is both set and enabled. A set flag whose enable is off raises no interrupt.
- R8: The read word returns the enables in bits 29:22 (enable i at bit 22+i) and the flags in bits 11:4. All other bits read zero.
- R9: A synchronous active-low reset clears all flags, all enables and the level.
- R10: The effect of a write or an event is visible on the read port in the cycle after the clock edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 36 | Command word: function bits, flag mask, level |
| evt_i | input | 8 | Hardware event pulses, one per flag |
| rd_data | output | 36 | Status word |
| irq_o | output | 1 | Interrupt request |
| irq_level_o | output | 3 | Programmed priority level |

## Verification
The hardest situation to reach is a single cycle in which an event pulse, a clear of the same flag and a set or enable of other flags all coincide. In that cycle the precedence of event over clear, and of set over clear, must both show. The stimulus drives writes that carry all four function bits at once and raises `evt_i` on a bit that the same write clears. Separate writes pair flags set with enables off, so that the summary bit is shown to stay low while flags are pending.

// File: rtl/sfc_pkg.sv
// Package: shared constants for the status flag controller.
// Assumes a word of at least 30 bits; field positions are fixed because
// software decodes them.
package sfc_pkg;
    localparam int NFLAG   = 8;
    localparam int LVL_W   = 3;
    localparam int WORD_W  = 36;
    // write-word fields
    localparam int FN_EN   = 15;
    localparam int FN_DIS  = 14;
    localparam int FN_CLR  = 13;
    localparam int FN_SET  = 12;
    localparam int SEL_LSB = 4;
    // read-word fields
    localparam int RD_EN_LSB = 22;
    localparam int RD_FL_LSB = 4;
    localparam int RD_SUM    = 3;

    // decoded per-flag actions of one write
    typedef struct packed {
        logic [NFLAG-1:0] en_on;
        logic [NFLAG-1:0] en_off;
        logic [NFLAG-1:0] fl_set;
        logic [NFLAG-1:0] fl_clr;
    } sfc_act_t;
endpackage

// File: rtl/sfc_decode.sv
// Module: sfc_decode
// Turns one command word into per-flag action masks and a level load.
// Assumes wr_data is only meaningful while wr_en is high.
module sfc_decode
    import sfc_pkg::*;
#(
    parameter int NF = NFLAG,
    parameter int LW = LVL_W,
    parameter int WW = WORD_W
) (
    input  logic          wr_en,
    input  logic [WW-1:0] wr_data,
    output sfc_act_t      act,
    output logic          lvl_we,
    output logic [LW-1:0] lvl_d
);
    logic [NF-1:0] sel;
    logic          unused_bits;

    assign sel         = wr_data[SEL_LSB +: NF];
    assign unused_bits = ^{wr_data[WW-1:SEL_LSB+NF+4], wr_data[SEL_LSB-1:LW]};

    // Gate each function bit by the strobe and spread it over the mask.
    always_comb begin
        act.en_on  = (wr_en && wr_data[FN_EN])  ? sel : '0;
        act.en_off = (wr_en && wr_data[FN_DIS]) ? sel : '0;
        act.fl_set = (wr_en && wr_data[FN_SET]) ? sel : '0;
        act.fl_clr = (wr_en && wr_data[FN_CLR]) ? sel : '0;
    end

    assign lvl_we = wr_en;
    assign lvl_d  = wr_data[LW-1:0];
endmodule

// File: rtl/sfc_flag_cell.sv
// Module: sfc_flag_cell
// One flag with its enable bit. Disable acts before enable, clear before
// set, and a hardware event overrides a clear in the same cycle.
module sfc_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic en_on,
    input  logic en_off,
    input  logic fl_set,
    input  logic fl_clr,
    input  logic evt,
    output logic en_q,
    output logic fl_q,
    output logic irq_term
);
    // Enable bit: remove first, then add.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= (en_q & ~en_off) | en_on;
    end

    // Flag bit: clear first, then set or event.
    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= 1'b0;
        else        fl_q <= (fl_q & ~fl_clr) | fl_set | evt;
    end

    assign irq_term = en_q & fl_q;
endmodule

// File: rtl/sfc_status.sv
// Module: sfc_status
// Packs enables, flags, summary and level into the status word and
// forms the summary interrupt. Unused bits are driven to zero.
module sfc_status
    import sfc_pkg::*;
#(
    parameter int NF = NFLAG,
    parameter int LW = LVL_W,
    parameter int WW = WORD_W
) (
    input  logic [NF-1:0] en_v,
    input  logic [NF-1:0] fl_v,
    input  logic [NF-1:0] term_v,
    input  logic [LW-1:0] lvl,
    output logic [WW-1:0] word,
    output logic          irq
);
    assign irq = |term_v;

    // Place each field at its fixed position.
    always_comb begin
        word                      = '0;
        word[RD_EN_LSB +: NF]     = en_v;
        word[RD_FL_LSB +: NF]     = fl_v;
        word[RD_SUM]              = irq;
        word[LW-1:0]              = lvl;
    end
endmodule

// File: rtl/sys_flag_ctrl.sv
// Module: sys_flag_ctrl (top)
// Eight condition flags with enables, a priority level and one
// interrupt request. Assumes evt_i pulses are synchronous to clk.
module sys_flag_ctrl
    import sfc_pkg::*;
#(
    parameter int NF = NFLAG,
    parameter int LW = LVL_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [WW-1:0] wr_data,
    input  logic [NF-1:0] evt_i,
    output logic [WW-1:0] rd_data,
    output logic          irq_o,
    output logic [LW-1:0] irq_level_o
);
    sfc_act_t      act;
    logic          lvl_we;
    logic [LW-1:0] lvl_d;
    logic [LW-1:0] lvl_q;
    logic [NF-1:0] en_v, fl_v, term_v;

    sfc_decode #(.NF(NF), .LW(LW), .WW(WW)) u_dec (
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .act    (act),
        .lvl_we (lvl_we),
        .lvl_d  (lvl_d)
    );

    // Priority level register, loaded by every write.
    always_ff @(posedge clk) begin
        if (!rst_n)      lvl_q <= '0;
        else if (lvl_we) lvl_q <= lvl_d;
    end

    for (genvar i = 0; i < NF; i++) begin : g_flag
        sfc_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_on   (act.en_on[i]),
            .en_off  (act.en_off[i]),
            .fl_set  (act.fl_set[i]),
            .fl_clr  (act.fl_clr[i]),
            .evt     (evt_i[i]),
            .en_q    (en_v[i]),
            .fl_q    (fl_v[i]),
            .irq_term(term_v[i])
        );
    end

    sfc_status #(.NF(NF), .LW(LW), .WW(WW)) u_stat (
        .en_v  (en_v),
        .fl_v  (fl_v),
        .term_v(term_v),
        .lvl   (lvl_q),
        .word  (rd_data),
        .irq   (irq_o)
    );

    assign irq_level_o = lvl_q;
endmodule

// File: rtl/sfc_checker.sv
// Module: sfc_checker
// Port-level properties of sys_flag_ctrl, attached by bind.
module sfc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [35:0] wr_data,
    input logic [7:0]  evt_i,
    input logic [35:0] rd_data,
    input logic        irq_o,
    input logic [2:0]  irq_level_o
);
    logic [7:0] sel, en_req, keep_fl, clr_only;
    assign sel      = wr_data[11:4];
    assign en_req   = (wr_en && wr_data[15]) ? sel : 8'h00;
    assign keep_fl  = ~evt_i & (wr_en ? ~sel : 8'hFF);
    assign clr_only = (wr_en && wr_data[13] && !wr_data[12]) ? (sel & ~evt_i) : 8'h00;

    // R2: requested enables are set after the write
    a_r2_enable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rd_data[29:22] & $past(en_req)) == $past(en_req)));
    // R3: a pure clear without event leaves the flag low
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rd_data[11:4] & $past(clr_only)) == 8'h00));
    // R4: unselected flags without event hold
    a_r4_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((rd_data[11:4] ^ $past(rd_data[11:4])) & $past(keep_fl)) == 8'h00));
    // R5: the level follows the last write
    a_r5_level: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (irq_level_o == $past(wr_data[2:0])));
    // R6: an event always lands
    a_r6_event: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((rd_data[11:4] & $past(evt_i)) == $past(evt_i)));
    // R7: request line and summary agree with set-and-enabled terms
    a_r7_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o == rd_data[3]) && (irq_o == |(rd_data[29:22] & rd_data[11:4])));
    // R8: unused read bits are zero
    a_r8_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[35:30] == 6'b0) && (rd_data[21:12] == 10'b0));
endmodule

bind sys_flag_ctrl sfc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .evt_i      (evt_i),
    .rd_data    (rd_data),
    .irq_o      (irq_o),
    .irq_level_o(irq_level_o)
);

// File: tb/tb_sys_flag_ctrl.sv
module tb_sys_flag_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic [7:0]  evt_i = '0;
    logic [35:0] rd_data;
    logic        irq_o;
    logic [2:0]  irq_level_o;

    sys_flag_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .evt_i(evt_i), .rd_data(rd_data), .irq_o(irq_o), .irq_level_o(irq_level_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [35:0] word;
        logic        irq;
        logic [2:0]  lvl;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    logic [7:0] m_en = '0, m_fl = '0;
    logic [2:0] m_lv = '0;

    function automatic logic [35:0] pack(logic [7:0] e, logic [7:0] f, logic [2:0] l);
        return {6'b0, e, 10'b0, f, |(e & f), l};
    endfunction

    // Driver: apply one cycle of stimulus and queue the expected status.
    task automatic step(input logic wr, input logic [3:0] fn, input logic [7:0] sel,
                        input logic [2:0] lv, input logic [7:0] ev, input string tag);
        exp_t x;
        logic [7:0] a_on, a_off, a_set, a_clr;
        @(negedge clk);
        wr_en   = wr;
        wr_data = {20'b0, fn, sel, 1'b0, lv};
        evt_i   = ev;
        a_on  = (wr && fn[3]) ? sel : 8'h00;
        a_off = (wr && fn[2]) ? sel : 8'h00;
        a_clr = (wr && fn[1]) ? sel : 8'h00;
        a_set = (wr && fn[0]) ? sel : 8'h00;
        m_en = (m_en & ~a_off) | a_on;
        m_fl = (m_fl & ~a_clr) | a_set | ev;
        if (wr) m_lv = lv;
        x.word = pack(m_en, m_fl, m_lv);
        x.irq  = |(m_en & m_fl);
        x.lvl  = m_lv;
        x.tag  = tag;
        q.push_back(x);
    endtask

    // Monitor: compare shortly after each edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            n_run++;
            if (rd_data !== x.word || irq_o !== x.irq || irq_level_o !== x.lvl) begin
                n_fail++;
                $display("FAIL %s: rd=%h irq=%b lvl=%0d expected rd=%h irq=%b lvl=%0d",
                         x.tag, rd_data, irq_o, irq_level_o, x.word, x.irq, x.lvl);
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R9: reset state, driving garbage during reset
        evt_i = 8'hFF; wr_en = 1'b1; wr_data = '1;
        repeat (3) @(negedge clk);
        wr_en = 1'b0; wr_data = '0; evt_i = '0;
        rst_n = 1'b1;
        @(posedge clk); #1;
        n_run++;
        if (rd_data !== '0 || irq_o !== 1'b0 || irq_level_o !== 3'd0) begin
            n_fail++;
            $display("FAIL R9 reset: rd=%h irq=%b expected rd=0 irq=0", rd_data, irq_o);
        end
        // fn bits: {enable, disable, clear, set}
        step(1, 4'b0001, 8'b0010_0000, 3'd5, 8'h00, "R3 set power-failure flag (R1 bit 9), not enabled R7");
        step(1, 4'b1000, 8'b0010_0001, 3'd5, 8'h00, "R2 enable flags 0,5 R7 irq on R10");
        step(1, 4'b0000, 8'h00,        3'd2, 8'h00, "R5 level load");
        step(1, 4'b0100, 8'b0010_0000, 3'd2, 8'h00, "R2 disable flag 5, irq off R7");
        step(1, 4'b1100, 8'b1100_0000, 3'd2, 8'h00, "R2 enable+disable: enable wins");
        step(1, 4'b0011, 8'b1000_0001, 3'd7, 8'h00, "R3 clear+set: set wins");
        step(1, 4'b0010, 8'b1010_0001, 3'd7, 8'h00, "R3 clear selected");
        step(0, 4'b0000, 8'h00,        3'd0, 8'b0100_0010, "R6 event without write R7");
        step(1, 4'b0010, 8'b0100_0010, 3'd1, 8'b0000_0010, "R6 event beats clear");
        step(1, 4'b1011, 8'b0000_1100, 3'd3, 8'h00, "R4 unselected unchanged, R8 zeros");
        step(1, 4'b1111, 8'b1111_0000, 3'd4, 8'b0000_0001, "R2 R3 all functions plus event");
        step(1, 4'b0110, 8'hFF,        3'd0, 8'h00, "R2 R3 clear all, disable all");
        step(0, 4'b1111, 8'hFF,        3'd6, 8'h00, "R4 no strobe, nothing changes");
        step(1, 4'b1001, 8'b0000_0001, 3'd6, 8'h00, "R1 bit4 front-end request enable+set R7");
        step(0, 4'b0000, 8'h00,        3'd0, 8'h00, "R10 idle hold");
        @(negedge clk); wr_en = 1'b0; evt_i = '0;
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule